// File: doc/BRIEF.md
# Interrupt Enable and Pending-Handler Controller

This block holds the interrupt part of a processor status word. That part is a global enable bit and a 3-bit field that names the handler to run next. A field value of zero means that no interrupt is pending. Hardware request lines and software writes both put handler numbers into this field. A small queue behind the field holds numbers that arrive while the field is already occupied. The queue keeps them for later service and does not discard them.

The controller asks the CPU to dispatch when the enable bit is set and the field holds a nonzero number. When the CPU acknowledges the dispatch, the enable bit clears so that handlers cannot nest. In the same edge the field takes the oldest queued number, or zero if the queue is empty. A return strobe at the end of a handler sets the enable bit again. The next pending number then dispatches in the cycle after the return.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the enable bit is 0, the handler field is 0, the queue is empty, dispatch is low and the overflow indication is low.
- R2: The status word carries the enable bit at bit 12 and the handler number at bits 15:13, with bit 13 as the least significant bit of the number. All other status bits read 0.
- R3: Dispatch is high exactly when the enable bit is 1 and the handler field is nonzero, and the dispatch number equals the field. A number that is pending while the enable bit is 0 stays in the field and is not dispatched.
- R4: An acknowledge while dispatch is high clears the enable bit at the next edge. At the same edge it loads the field with the oldest queued number, or with 0 when the queue is empty. An acknowledge while dispatch is low has no effect.
- R5: A return strobe sets the enable bit at the next edge. If an accepted acknowledge occurs in the same cycle, the acknowledge wins and the enable bit clears.
- R6: Bit k of the request input posts handler number k+1 and is captured at the next edge. If the field is empty the number goes into the field; otherwise it is appended to the queue.
- R7: Requests raised in the same cycle are placed in ascending order of handler number, so the lowest number is served first.
- R8: The queue holds 4 numbers behind the field. A request that finds the field and the queue full is dropped and leaves the stored numbers unchanged. A dropped request sets an overflow indication that stays high until reset.
- R9: A software write loads the enable bit from data bit 12 and the field from data bits 15:13 at the next edge, and it overrides an acknowledge and a return in the same cycle. The write leaves the queue untouched. Requests raised in the same cycle are appended to the queue.
- R10: Queued numbers leave in first-in, first-out order across cycles. When the field holds 0 and the queue is not empty, the field takes the queue head at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Request lines; bit k posts handler k+1 |
| ack_i | input | 1 | CPU accepts the dispatched handler |
| ret_i | input | 1 | Return from handler; re-enables interrupts |
| sw_we_i | input | 1 | Software write strobe for the status word |
| sw_wdata_i | input | 16 | Software write data (bits 15:12 used) |
| status_o | output | 16 | Status word with enable and handler bits |
| dispatch_o | output | 1 | Request to the CPU to run a handler |
| disp_num_o | output | 3 | Handler number to dispatch |
| overflow_o | output | 1 | Sticky dropped-request indication |

## Verification
The bench uses the default configuration: seven request lines and a queue 4 entries deep, so up to five numbers can be pending at once. With only seven lines, it can sweep every one of the 127 simultaneous request patterns from reset. For each pattern it drains the full service order through return and acknowledge cycles, which covers lowest-first ordering and the drop-on-full boundary at six or more requests. Directed sequences then cover software posting over a busy queue, collisions between acknowledge and return, and ignored acknowledges.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int unsigned STAT_W  = 16;
  localparam int unsigned NUM_W   = 3;
  localparam int unsigned IE_POS  = 12;
  localparam int unsigned NUM_POS = 13;

  // Assemble the status word from the enable bit and the pending number.
  function automatic logic [STAT_W-1:0] pack_status(input logic ie,
                                                    input logic [NUM_W-1:0] num);
    logic [STAT_W-1:0] w;
    w = '0;
    w[IE_POS] = ie;
    w[NUM_POS +: NUM_W] = num;
    return w;
  endfunction

  // Handler number posted by request line index k.
  function automatic logic [NUM_W-1:0] line_to_num(input int unsigned k);
    return NUM_W'(k + 1);
  endfunction

endpackage

// File: rtl/irq_ie_ctl.sv
module irq_ie_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_we_i,
  input  logic sw_ie_i,
  input  logic take_i,
  input  logic ret_i,
  output logic ie_o
);
  logic ie_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       ie_q <= 1'b0;
    else if (sw_we_i)  ie_q <= sw_ie_i;
    else if (take_i)   ie_q <= 1'b0;
    else if (ret_i)    ie_q <= 1'b1;
  end

  assign ie_o = ie_q;
endmodule

// File: rtl/irq_ovf_flag.sv
module irq_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  output logic ovf_o
);
  logic ovf_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     ovf_q <= 1'b0;
    else if (drop_i) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/irq_queue.sv
module irq_queue #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned NUM_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sw_we_i,
  input  logic [NUM_W-1:0]          sw_num_i,
  input  logic                      pop_i,
  input  logic [NUM_SRC-1:0]        req_i,
  output logic [NUM_W-1:0]          slot_o,
  output logic [NUM_W-1:0]          head_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                      drop_o
);
  import irq_ctl_pkg::*;

  localparam int unsigned ENT   = DEPTH + 1;
  localparam int unsigned IDX_W = $clog2(ENT + 1);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Entry 0 is the visible handler field; entries 1..DEPTH form the queue.
  // A zero entry is empty; occupied queue entries are contiguous from 1.
  logic [NUM_W-1:0] ent_q   [ENT];
  logic [NUM_W-1:0] base_c  [ENT];
  logic [NUM_W-1:0] cmp_c   [ENT];
  logic [NUM_W-1:0] nxt_c   [ENT];
  logic [IDX_W-1:0] pos_c;
  logic             drop_c;

  always_comb begin
    base_c = ent_q;
    if (sw_we_i)    base_c[0] = sw_num_i;
    else if (pop_i) base_c[0] = '0;

    cmp_c = base_c;
    if (!sw_we_i && base_c[0] == '0) begin
      for (int i = 0; i < ENT - 1; i++) cmp_c[i] = base_c[i+1];
      cmp_c[ENT-1] = '0;
    end

    pos_c = IDX_W'(ENT);
    for (int i = ENT - 1; i >= 0; i--) begin
      if (cmp_c[i] == '0 && (i >= 1 || !sw_we_i)) pos_c = IDX_W'(i);
    end

    nxt_c  = cmp_c;
    drop_c = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (req_i[s]) begin
        if (pos_c < IDX_W'(ENT)) begin
          nxt_c[pos_c] = line_to_num(s);
          pos_c = pos_c + 1'b1;
        end else begin
          drop_c = 1'b1;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < ENT; g++) begin : g_ent
      always_ff @(posedge clk_i) begin
        if (!rst_ni) ent_q[g] <= '0;
        else         ent_q[g] <= nxt_c[g];
      end
    end
  endgenerate

  always_comb begin
    cnt_o = '0;
    for (int i = 1; i < ENT; i++) begin
      if (ent_q[i] != '0) cnt_o = cnt_o + CNT_W'(1);
    end
  end

  assign slot_o = ent_q[0];
  assign head_o = ent_q[1];
  assign drop_o = drop_c;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned DEPTH   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [6:0]  req_i,
  input  logic        ack_i,
  input  logic        ret_i,
  input  logic        sw_we_i,
  input  logic [15:0] sw_wdata_i,
  output logic [15:0] status_o,
  output logic        dispatch_o,
  output logic [2:0]  disp_num_o,
  output logic        overflow_o
);
  import irq_ctl_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             ie_q;
  logic [NUM_W-1:0] slot_num;
  logic [NUM_W-1:0] fifo_head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             take_evt;
  logic             drop_evt;

  // Named events for the checker.
  assign dispatch_o = ie_q && (slot_num != '0);
  assign take_evt   = ack_i && dispatch_o && !sw_we_i;

  irq_ie_ctl u_ie (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sw_we_i (sw_we_i),
    .sw_ie_i (sw_wdata_i[IE_POS]),
    .take_i  (take_evt),
    .ret_i   (ret_i),
    .ie_o    (ie_q)
  );

  irq_queue #(
    .NUM_SRC (NUM_SRC),
    .DEPTH   (DEPTH),
    .NUM_W   (NUM_W)
  ) u_queue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_we_i  (sw_we_i),
    .sw_num_i (sw_wdata_i[NUM_POS +: NUM_W]),
    .pop_i    (take_evt),
    .req_i    (req_i[NUM_SRC-1:0]),
    .slot_o   (slot_num),
    .head_o   (fifo_head),
    .cnt_o    (fifo_cnt),
    .drop_o   (drop_evt)
  );

  irq_ovf_flag u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drop_i (drop_evt),
    .ovf_o  (overflow_o)
  );

  assign status_o   = pack_status(ie_q, slot_num);
  assign disp_num_o = slot_num;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [6:0]                  req_i,
  input logic                        ret_i,
  input logic                        sw_we_i,
  input logic [15:0]                 sw_wdata_i,
  input logic [15:0]                 status_o,
  input logic                        dispatch_o,
  input logic [2:0]                  disp_num_o,
  input logic                        overflow_o,
  input logic                        take_evt,
  input logic                        drop_evt,
  input logic [2:0]                  fifo_head,
  input logic [$clog2(DEPTH+1)-1:0]  fifo_cnt
);
  assert_ack_clears_ie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_evt |=> !status_o[12]);

  assert_ack_refill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_evt && fifo_cnt != '0) |=> disp_num_o == $past(fifo_head));

  assert_ack_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_evt && fifo_cnt == '0 && req_i == '0) |=> disp_num_o == 3'd0);

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_o && !sw_we_i && disp_num_o != 3'd0) |=> disp_num_o == $past(disp_num_o));

  assert_ret_sets_ie_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !sw_we_i && !take_evt) |=> status_o[12]);

  assert_sw_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> status_o[15:12] == $past(sw_wdata_i[15:12]));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_drop_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_evt |=> overflow_o);
endmodule

bind irq_pend_ctrl irq_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ret_i      (ret_i),
  .sw_we_i    (sw_we_i),
  .sw_wdata_i (sw_wdata_i),
  .status_o   (status_o),
  .dispatch_o (dispatch_o),
  .disp_num_o (disp_num_o),
  .overflow_o (overflow_o),
  .take_evt   (take_evt),
  .drop_evt   (drop_evt),
  .fifo_head  (fifo_head),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/tb_irq_pend_ctrl.sv
`timescale 1ns/1ps
module tb_irq_pend_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  req_i = '0;
  logic        ack_i = 1'b0;
  logic        ret_i = 1'b0;
  logic        sw_we_i = 1'b0;
  logic [15:0] sw_wdata_i = '0;
  logic [15:0] status_o;
  logic        dispatch_o;
  logic [2:0]  disp_num_o;
  logic        overflow_o;

  int checks = 0;
  int fails  = 0;

  // Reference state: field, queue of 4, enable, overflow.
  int m_ie, m_slot, m_ovf, m_cnt;
  int m_q[4];

  always #2.5 clk_i = ~clk_i;

  irq_pend_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ack_i(ack_i), .ret_i(ret_i),
    .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i), .status_o(status_o),
    .dispatch_o(dispatch_o), .disp_num_o(disp_num_o), .overflow_o(overflow_o)
  );

  task automatic compare(input string tag);
    logic [15:0] exp_stat;
    logic        exp_disp;
    exp_stat = 16'((m_ie << 12) | (m_slot << 13));
    exp_disp = (m_ie != 0) && (m_slot != 0);
    checks++;
    if (status_o !== exp_stat || dispatch_o !== exp_disp ||
        disp_num_o !== 3'(m_slot) || overflow_o !== 1'(m_ovf)) begin
      fails++;
      $display("FAIL %s: stat=%h disp=%b num=%0d ovf=%b expected stat=%h disp=%b num=%0d ovf=%0d",
               tag, status_o, dispatch_o, disp_num_o, overflow_o,
               exp_stat, exp_disp, m_slot, m_ovf);
    end
  endtask

  task automatic model_step(input logic [6:0] rq, input logic ak, input logic rt,
                            input logic we, input logic [15:0] wd);
    bit disp;
    disp = (m_ie != 0) && (m_slot != 0);
    if (we) begin
      m_ie = wd[12];
      m_slot = int'(wd[15:13]);
    end else begin
      if (ak && disp) begin
        m_ie = 0;
        m_slot = 0;
      end else if (rt) begin
        m_ie = 1;
      end
      if (m_slot == 0 && m_cnt > 0) begin
        m_slot = m_q[0];
        for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
        m_q[3] = 0;
        m_cnt--;
      end
    end
    for (int s = 1; s <= 7; s++) begin
      if (rq[s-1]) begin
        if (!we && m_slot == 0) m_slot = s;
        else if (m_cnt < 4) begin
          m_q[m_cnt] = s;
          m_cnt++;
        end else m_ovf = 1;
      end
    end
  endtask

  // Called at a falling edge; drives one cycle and checks the result.
  task automatic step(input logic [6:0] rq, input logic ak, input logic rt,
                      input logic we, input logic [15:0] wd, input string tag);
    req_i = rq; ack_i = ak; ret_i = rt; sw_we_i = we; sw_wdata_i = wd;
    model_step(rq, ak, rt, we, wd);
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = '0; ack_i = 0; ret_i = 0; sw_we_i = 0; sw_wdata_i = '0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    req_i = '0; ack_i = 0; ret_i = 0; sw_we_i = 0; sw_wdata_i = '0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    m_ie = 0; m_slot = 0; m_ovf = 0; m_cnt = 0;
    for (int i = 0; i < 4; i++) m_q[i] = 0;
    compare("R1 reset state");
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R7 R8 R6: every simultaneous pattern, then drained via return/ack.
    for (int pat = 1; pat < 128; pat++) begin
      do_reset();
      step(7'(pat), 0, 0, 0, '0, "R7 capture lowest first");
      step('0, 1, 0, 0, '0, "R4 ack ignored while disabled");
      for (int k = 0; k < 6; k++) begin
        step('0, 0, 1, 0, '0, "R5 return enables");
        step('0, 1, 0, 0, '0, "R10 ack refills in order");
      end
    end

    // R9 R2: software write posts a number and ignores low data bits.
    do_reset();
    step('0, 0, 0, 1, 16'hBFFF, "R9 sw write sets ie and field");
    step('0, 0, 0, 1, 16'h4EDC, "R2 status layout");
    // R3: pending but disabled -> no dispatch.
    do_reset();
    step(7'b0000100, 0, 0, 0, '0, "R6 request enters field");
    step('0, 0, 0, 0, '0, "R3 disabled holds pending");
    step('0, 0, 1, 0, '0, "R3 dispatch after return");
    // R5: return and accepted ack together -> ack wins.
    step(7'b0000001, 0, 0, 0, '0, "R6 request queued behind field");
    step('0, 1, 1, 0, '0, "R5 ack beats return");
    step('0, 0, 1, 0, '0, "R5 return re-enables");
    // R10: requests across cycles keep arrival order.
    do_reset();
    step(7'b0000100, 0, 0, 0, '0, "R10 first arrival");
    step(7'b0000001, 0, 0, 0, '0, "R10 second arrival");
    step(7'b0100000, 0, 0, 0, '0, "R10 third arrival");
    step(7'b0000010, 1, 1, 0, '0, "R10 ack with new request");
    for (int k = 0; k < 4; k++) begin
      step('0, 0, 1, 0, '0, "R10 return");
      step('0, 1, 0, 0, '0, "R10 ordered service");
    end
    // R8: fill over several cycles, then overflow is sticky.
    do_reset();
    step(7'b0000011, 0, 0, 0, '0, "R8 fill a");
    step(7'b0001100, 0, 0, 0, '0, "R8 fill b");
    step(7'b0010000, 0, 0, 0, '0, "R8 fill c");
    step(7'b1000000, 0, 0, 0, '0, "R8 drop on full");
    step('0, 0, 1, 0, '0, "R8 overflow stays");
    step('0, 1, 0, 0, '0, "R8 stored numbers intact");
    // R9: software write overrides ack and appends same-cycle requests.
    step(7'b0100000, 1, 1, 1, 16'h6000, "R9 write beats ack, request queued");
    step('0, 0, 0, 1, 16'h1000, "R9 write zero field");
    step('0, 0, 0, 0, '0, "R10 refill after zero field");
    step('0, 1, 0, 0, '0, "R4 ack pops");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule